// File: doc/BRIEF.md
# Fan Rotor Lock Guard

The block watches a fan rotor for missing commutation and shuts the drive off when the rotor is stuck. A saturating up/down counter takes the place of an external timing capacitor. While no speed-pulse edge arrives, the counter climbs at a prescaled rate. Every speed-pulse edge seen during normal running empties the counter. If the counter reaches its upper threshold, the block enters lock protection. In that state it raises a drive-off flag and releases the rotation-status output high, in the manner of an open-drain line.

While locked, the counter falls at a rate ten times slower than its climb. This makes the off time much longer than the detection time. When the counter reaches the lower threshold, lock is released and a one-cycle soft-restart request is issued. The rotation status drops back low only when a real speed-pulse edge follows the restart. Standby entry discharges the counter. If standby is entered while locked, the block also leaves lock and drives the status low. A strap input disables the whole protection.

Top module: `fan_lock_guard`

## Requirements
- R1: After reset `lock_prot` is 0, `restart` is 0 and `rot_status` is 1 (not yet proven rotating).
- R2: With `lock_en`=1, no standby and no `spd_edge`, `lock_prot` rises exactly HIGH*UP_DIV cycles after reset, after the last `spd_edge` cycle, or after the last lock release. Here FULL = 2^CNT_W-1, HIGH = floor(FULL*25/33) and LOW = floor(FULL*8/33). The defaults give 193*4 = 772 cycles.
- R3: `rot_status` is 1 in every cycle in which `lock_prot` is 1, and it rises no later than `lock_prot`.
- R4: When the lock has not been cut short, `lock_prot` falls exactly (HIGH-LOW)*UP_DIV*DN_RATIO cycles after it rose. With the defaults this is 132*40 = 5280 cycles. `restart` is 1 for exactly that one cycle.
- R5: After a restart, `rot_status` stays 1 until a `spd_edge` cycle. It is 0 in the cycle after that edge.
- R6: `spd_edge` has no effect while `lock_prot` is 1. Lock, status and the release time are all unchanged.
- R7: Any `spd_edge` while unlocked restarts the detection window. Edges spaced HIGH*UP_DIV-1 cycles or less apart never produce lock.
- R8: With `lock_en`=1, `stby_clear` or `stby_active` during lock drops `lock_prot` and `rot_status` to 0 in the next cycle, and no `restart` is issued.
- R9: While `stby_active` is 1 no lock can build up. After it falls, a full HIGH*UP_DIV quiet cycles are needed for lock.
- R10: With `lock_en`=0, `lock_prot` is 0 from the next cycle on, with no `restart` and no change of `rot_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_en | input | 1 | Strap: 1 enables lock protection |
| spd_edge | input | 1 | One-cycle pulse on each speed-pulse transition |
| stby_active | input | 1 | Standby mode is active |
| stby_clear | input | 1 | One-cycle discharge request on standby entry |
| lock_prot | output | 1 | Lock protection active (drive off) |
| restart | output | 1 | One-cycle soft-start restart request |
| rot_status | output | 1 | Rotation status: 0 rotating, 1 locked or unproven |

## Verification
The first pattern is a quiet rotor with no edges. It measures the exact detection and off times, and it separates an off-by-one in either prescaler from a wrong threshold. Periodic edges just inside the window then show whether an edge really restarts the window rather than only pausing it. Edges injected during lock show whether they are ignored. Standby pulses, held standby and strap toggling separate the three ways of leaving lock: natural release with restart, standby release with the status forced low, and strap release with the status unchanged. A long random mix of edge gaps, standby events and strap drops is compared cycle by cycle against a cycle-count model. This catches interactions such as an edge landing in the same cycle as lock entry.

// File: rtl/fan_lock_pkg.sv
package fan_lock_pkg;

   typedef enum logic {
      PH_WATCH  = 1'b0,
      PH_LOCKED = 1'b1
   } lock_phase_e;

   function automatic int unsigned frac_of(input int unsigned full,
                                           input int unsigned num,
                                           input int unsigned den);
      return (full * num) / den;
   endfunction

endpackage

// File: rtl/flg_tick_div.sv
module flg_tick_div #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic tick
);

   generate
      if (DIV < 1) begin : g_bad_div
         $error("flg_tick_div: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int unsigned PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);

         logic [PW-1:0] pre_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (clr) begin
               pre_q <= '0;
            end else if (run) begin
               pre_q <= (pre_q == LAST) ? '0 : pre_q + PW'(1);
            end
         end

         assign tick = run && (pre_q == LAST);

         AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            pre_q <= LAST); // R2

         AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> !tick); // R7
      end
   endgenerate

endmodule

// File: rtl/flg_ramp.sv
module flg_ramp #(
   parameter int unsigned W    = 8,
   parameter int unsigned HIGH = 193,
   parameter int unsigned LOW  = 61
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         up,
   input  logic         dn,
   output logic [W-1:0] cnt,
   output logic         hit_high,
   output logic         hit_low
);

   localparam logic [W-1:0] HI_V  = W'(HIGH);
   localparam logic [W-1:0] HI_M1 = W'(HIGH - 1);
   localparam logic [W-1:0] LO_P1 = W'(LOW + 1);

   generate
      if (HIGH >= (1 << W)) begin : g_bad_high
         $error("flg_ramp: HIGH exceeds counter range");
      end
      if (LOW + 1 >= HIGH) begin : g_bad_gap
         $error("flg_ramp: LOW must be below HIGH-1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   assign hit_high = up && (cnt_q >= HI_M1);
   assign hit_low  = dn && (cnt_q <= LO_P1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (hit_high) begin
         cnt_q <= HI_V;
      end else if (hit_low) begin
         cnt_q <= '0;
      end else if (up) begin
         cnt_q <= cnt_q + W'(1);
      end else if (dn) begin
         cnt_q <= cnt_q - W'(1);
      end
   end

   assign cnt = cnt_q;

   AST_CNT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= HI_V); // R2

   AST_DN_ABOVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      dn |-> (cnt_q > W'(LOW))); // R4

   AST_NO_UPDOWN: assert property (@(posedge clk) disable iff (!rst_n)
      !(up && dn)); // R6

endmodule

// File: rtl/flg_status.sv
module flg_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set_lock,
   input  logic stby_drop,
   input  logic rot_edge,
   input  logic release_now,
   output logic rot_status,
   output logic restart
);

   logic stat_q;
   logic rst_pulse_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= 1'b1;
      end else if (set_lock) begin
         stat_q <= 1'b1;
      end else if (stby_drop || rot_edge) begin
         stat_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rst_pulse_q <= 1'b0;
      end else begin
         rst_pulse_q <= release_now;
      end
   end

   assign rot_status = stat_q;
   assign restart    = rst_pulse_q;

   AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse_q |=> !rst_pulse_q); // R4

   AST_RESTART_KEEPS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse_q |-> stat_q); // R5

endmodule

// File: rtl/fan_lock_guard.sv
module fan_lock_guard
   import fan_lock_pkg::*;
#(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned UP_DIV    = 4,
   parameter int unsigned DN_RATIO  = 10,
   parameter int unsigned HI_NUM    = 25,
   parameter int unsigned LO_NUM    = 8,
   parameter int unsigned SCALE_DEN = 33
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_en,
   input  logic spd_edge,
   input  logic stby_active,
   input  logic stby_clear,
   output logic lock_prot,
   output logic restart,
   output logic rot_status
);

   localparam int unsigned FULL     = (1 << CNT_W) - 1;
   localparam int unsigned HIGH_LVL = frac_of(FULL, HI_NUM, SCALE_DEN);
   localparam int unsigned LOW_LVL  = frac_of(FULL, LO_NUM, SCALE_DEN);
   localparam int unsigned DN_DIV   = UP_DIV * DN_RATIO;

   generate
      if (CNT_W < 2 || CNT_W > 24) begin : g_bad_width
         $error("fan_lock_guard: CNT_W out of range");
      end
      if (SCALE_DEN == 0 || HI_NUM > SCALE_DEN) begin : g_bad_high_frac
         $error("fan_lock_guard: upper threshold fraction invalid");
      end
      if (LO_NUM >= HI_NUM) begin : g_bad_low_frac
         $error("fan_lock_guard: lower threshold must be below upper");
      end
      if (DN_RATIO < 1 || UP_DIV < 1) begin : g_bad_rate
         $error("fan_lock_guard: rates must be at least 1");
      end
   endgenerate

   lock_phase_e  phase_q;
   logic         in_lock;
   logic         stby_any;
   logic         watching;
   logic         up_run, dn_run;
   logic         up_tick, dn_tick;
   logic         ramp_clr;
   logic         hit_high, hit_low;
   logic [CNT_W-1:0] level;

   assign in_lock  = (phase_q == PH_LOCKED);
   assign stby_any = stby_clear || stby_active;
   assign watching = !in_lock && lock_en && !stby_any;
   assign up_run   = watching && !spd_edge;
   assign dn_run   = in_lock && lock_en && !stby_any;
   assign ramp_clr = !lock_en || stby_any || (!in_lock && spd_edge);

   flg_tick_div #(.DIV(UP_DIV)) u_up_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!up_run),
      .run   (up_run),
      .tick  (up_tick)
   );

   flg_tick_div #(.DIV(DN_DIV)) u_dn_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!dn_run),
      .run   (dn_run),
      .tick  (dn_tick)
   );

   flg_ramp #(
      .W    (CNT_W),
      .HIGH (HIGH_LVL),
      .LOW  (LOW_LVL)
   ) u_ramp (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (ramp_clr),
      .up       (up_tick),
      .dn       (dn_tick),
      .cnt      (level),
      .hit_high (hit_high),
      .hit_low  (hit_low)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_WATCH;
      end else begin
         unique case (phase_q)
            PH_WATCH: begin
               if (hit_high) phase_q <= PH_LOCKED;
            end
            PH_LOCKED: begin
               if (!lock_en || stby_any || hit_low) phase_q <= PH_WATCH;
            end
            default: phase_q <= PH_WATCH;
         endcase
      end
   end

   flg_status u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_lock    (hit_high),
      .stby_drop   (in_lock && lock_en && stby_any),
      .rot_edge    (!in_lock && spd_edge),
      .release_now (hit_low),
      .rot_status  (rot_status),
      .restart     (restart)
   );

   assign lock_prot = in_lock;

   AST_LOCK_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
      lock_prot |-> rot_status); // R3

   AST_RESTART_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> ($past(lock_prot) && !lock_prot)); // R4

   AST_EDGE_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (spd_edge && !lock_prot) |=> !lock_prot); // R7

   AST_STBY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_prot && lock_en && stby_any) |=> (!lock_prot && !rot_status && !restart)); // R8

   AST_STBY_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (stby_active && !lock_prot) |=> !lock_prot); // R9

   AST_STRAP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_en |=> (!lock_prot && !restart)); // R10

   AST_LEVEL_IN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_prot && !$past(lock_prot)) |-> (level == CNT_W'(HIGH_LVL))); // R2

endmodule

// File: tb/fan_lock_guard_test.sv
`timescale 1ns/1ps
module fan_lock_guard_test;

   localparam int FULL  = 255;
   localparam int HI    = (FULL * 25) / 33;
   localparam int LO    = (FULL * 8) / 33;
   localparam int T_UP  = HI * 4;
   localparam int T_DN  = (HI - LO) * 4 * 10;

   logic clk = 1'b0;
   logic rst_n, lock_en, spd_edge, stby_active, stby_clear;
   logic lock_prot, restart, rot_status;

   int total = 0;
   int bad   = 0;
   int mfails = 0;
   bit done  = 1'b0;
   bit cmp_on = 1'b0;

   always #2.5 clk = ~clk;

   fan_lock_guard uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .lock_en     (lock_en),
      .spd_edge    (spd_edge),
      .stby_active (stby_active),
      .stby_clear  (stby_clear),
      .lock_prot   (lock_prot),
      .restart     (restart),
      .rot_status  (rot_status)
   );

   // Cycle-count reference model built from the requirements
   bit m_lock, m_stat, m_rst;
   int quiet, age;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_lock = 0; m_stat = 1; m_rst = 0; quiet = 0; age = 0;
      end else begin
         m_rst = 0;
         if (!m_lock) begin
            if (!lock_en || stby_active || stby_clear || spd_edge) quiet = 0;
            else quiet++;
            if (spd_edge) m_stat = 0;
            if (quiet == T_UP) begin
               m_lock = 1; m_stat = 1; age = 0; quiet = 0;
            end
         end else if (!lock_en) begin
            m_lock = 0; quiet = 0;
         end else if (stby_active || stby_clear) begin
            m_lock = 0; m_stat = 0; quiet = 0;
         end else begin
            age++;
            if (age == T_DN) begin
               m_lock = 0; m_rst = 1; quiet = 0;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (cmp_on && rst_n && !done) begin
         total++;
         if (lock_prot !== m_lock || rot_status !== m_stat || restart !== m_rst) begin
            bad++;
            if (mfails < 8)
               $display("FAIL R2/R3/R4/R6/R8/R10 model lock,status,restart act=%0d%0d%0d exp=%0d%0d%0d",
                        lock_prot, rot_status, restart, m_lock, m_stat, m_rst);
            mfails++;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic edge_pulse();
      spd_edge = 1'b1; step(1); spd_edge = 1'b0;
   endtask

   initial begin
      #(190000 * 5);
      if (!done) begin
         done = 1'b1;
         bad++; total++;
         $display("FAIL watchdog act=1 exp=0");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0F4A));
      rst_n = 0; lock_en = 1; spd_edge = 0; stby_active = 0; stby_clear = 0;
      repeat (4) @(negedge clk);
      chk(lock_prot === 0, "R1 lock_prot after reset", lock_prot, 0);
      chk(restart === 0, "R1 restart after reset", restart, 0);
      chk(rot_status === 1, "R1 rot_status after reset", rot_status, 1);
      rst_n = 1; cmp_on = 1;

      // R2 / R3: quiet rotor locks at exactly T_UP
      step(T_UP - 1);
      chk(lock_prot === 0, "R2 no lock one cycle early", lock_prot, 0);
      step(1);
      chk(lock_prot === 1, "R2 lock at window end", lock_prot, 1);
      chk(rot_status === 1, "R3 status high in lock", rot_status, 1);

      // R6: edges ignored during lock
      for (int i = 0; i < 3; i++) begin
         edge_pulse();
         chk(lock_prot === 1 && rot_status === 1, "R6 edge ignored in lock",
             {lock_prot, rot_status}, 3);
      end

      // R4: release timing and single restart pulse
      step(T_DN - 4);
      chk(lock_prot === 1 && restart === 0, "R4 still locked before release",
          {lock_prot, restart}, 2);
      step(1);
      chk(lock_prot === 0 && restart === 1, "R4 release with restart",
          {lock_prot, restart}, 1);
      step(1);
      chk(restart === 0, "R4 restart lasts one cycle", restart, 0);
      chk(rot_status === 1, "R5 status held after restart", rot_status, 1);
      step(10);
      chk(rot_status === 1, "R5 status held without edge", rot_status, 1);
      edge_pulse();
      chk(rot_status === 0, "R5 status low after edge", rot_status, 0);

      // R7: edges just inside the window never lock
      for (int i = 0; i < 4; i++) begin
         step(T_UP - 2);
         chk(lock_prot === 0, "R7 no lock before edge", lock_prot, 0);
         edge_pulse();
      end
      step(T_UP - 1);
      chk(lock_prot === 0, "R7 window restarted by edge", lock_prot, 0);
      step(1);
      chk(lock_prot === 1, "R7 lock after full window", lock_prot, 1);

      // R8: standby entry while locked
      stby_clear = 1; step(1); stby_clear = 0;
      chk(lock_prot === 0 && rot_status === 0 && restart === 0,
          "R8 standby releases lock", {lock_prot, rot_status, restart}, 0);
      step(50);
      chk(restart === 0 && lock_prot === 0, "R8 no later restart",
          {lock_prot, restart}, 0);

      // R9: held standby blocks lock
      stby_active = 1;
      step(2 * T_UP);
      chk(lock_prot === 0, "R9 no lock in standby", lock_prot, 0);
      stby_active = 0;
      step(T_UP - 1);
      chk(lock_prot === 0, "R9 full window after standby", lock_prot, 0);
      step(1);
      chk(lock_prot === 1, "R9 lock after standby window", lock_prot, 1);

      // R10: strap off
      lock_en = 0; step(1);
      chk(lock_prot === 0 && restart === 0 && rot_status === 1,
          "R10 strap off releases", {lock_prot, restart, rot_status}, 1);
      step(2 * T_UP);
      chk(lock_prot === 0, "R10 never locks with strap off", lock_prot, 0);
      lock_en = 1;
      edge_pulse();

      // Random mix, checked against the model every cycle
      for (int i = 0; i < 110; i++) begin
         int gap;
         int act;
         gap = int'($urandom_range(1, 1300));
         step(gap);
         act = int'($urandom_range(0, 9));
         case (act)
            0: begin stby_clear = 1; step(1); stby_clear = 0; end
            1: begin stby_active = 1; step(int'($urandom_range(1, 300))); stby_active = 0; end
            2: begin lock_en = 0; step(int'($urandom_range(1, 50))); lock_en = 1; end
            default: edge_pulse();
         endcase
      end
      step(2);

      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule